// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block sits in the execute stage of a 32-bit RISC-V core and decides where the program counter goes next. It receives the current PC from its own register, two register operands, an immediate that decode has already sign-extended, and a four-bit class select. For each class it produces four things at once: the next PC, a flag that says control left the sequential path, a write-enable for the destination register, and the value to write there.

The unit resolves all six conditional branches, both kinds of jump-and-link, and the two upper-immediate forms: load-upper and add-upper-to-PC. Anything else falls through to PC+4.

The PC register is part of the block. It loads the computed next PC on a clock edge when `step` is high. It holds when `step` is low, and returns to a reset vector under synchronous reset. The four results are combinational functions of the registered PC and the present inputs. The link value is therefore always formed from the PC of the instruction being resolved, even when the destination register is also the jump base.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_out` takes the reset vector (0 by default), whatever `step` is.
- R2: Class 0 (sequential) gives `next_pc` = `pc_out`+4, `taken` = 0 and `wb_en` = 0.
- R3: Class 1 is taken when `rs1_val` equals `rs2_val`, and class 2 is taken when they differ.
- R4: Classes 3 and 4 compare the operands as two's-complement values. Class 3 is taken on rs1 < rs2 and class 4 on rs1 >= rs2.
- R5: Classes 5 and 6 make the same less-than and greater-or-equal tests as unsigned values.
- R6: For classes 1 to 6, a taken branch gives `next_pc` = `pc_out` + `imm_val` and a branch not taken gives `pc_out`+4. `wb_en` stays 0 in both cases.
- R7: Class 7 (jump-and-link) sets `taken` = 1 and `next_pc` = `pc_out` + `imm_val`. It also writes `pc_out`+4 with `wb_en` = 1.
- R8: Class 8 (register jump-and-link) sets `taken` = 1 and `next_pc` = (`rs1_val` + `imm_val`) with bit 0 cleared. It writes the current `pc_out`+4.
- R9: Class 10 (load-upper) writes `imm_val` shifted left by 12 (its low 20 bits land in bits 31:12) with `wb_en` = 1. It gives `taken` = 0 and `next_pc` = `pc_out`+4.
- R10: Class 9 (add-upper-to-PC) writes `pc_out` + (`imm_val` << 12) with `wb_en` = 1. It gives `taken` = 0 and `next_pc` = `pc_out`+4.
- R11: At a rising edge with `rst` low, `pc_out` loads `next_pc` when `step` = 1 and keeps its value when `step` = 0.
- R12: Class codes 11 to 15 behave exactly as class 0.
- R13: `wb_val` is 0 whenever `wb_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance the PC register this cycle |
| op_sel | input | 4 | Instruction class select (codes in R2 to R12) |
| rs1_val | input | 32 | First register operand, also the register-jump base |
| rs2_val | input | 32 | Second register operand |
| imm_val | input | 32 | Sign-extended immediate, or the raw upper immediate in bits 19:0 for classes 9 and 10 |
| pc_out | output | 32 | Current program counter |
| next_pc | output | 32 | PC of the following instruction |
| taken | output | 1 | High when control leaves the sequential path |
| wb_en | output | 1 | High when the class writes a destination register |
| wb_val | output | 32 | Value for the destination register |

## Verification
`next_pc`, `taken`, `wb_en` and `wb_val` are due in the same cycle as the inputs that produce them, with no register in the path. `pc_out` changes only at the next rising edge. The bench drives inputs on the falling edge and samples the combinational results 1 ns later, once they have settled. It compares `pc_out` with its own model PC at the following falling edge, which is one register stage later. The model PC advances, holds or resets according to what was driven before that edge.

// File: rtl/nextpc_pkg.sv
`timescale 1ns/1ps
package nextpc_pkg;

    // Instruction class codes seen on op_sel
    typedef enum logic [3:0] {
        OP_SEQ   = 4'd0,
        OP_BEQ   = 4'd1,
        OP_BNE   = 4'd2,
        OP_BLT   = 4'd3,
        OP_BGE   = 4'd4,
        OP_BLTU  = 4'd5,
        OP_BGEU  = 4'd6,
        OP_JAL   = 4'd7,
        OP_JALR  = 4'd8,
        OP_AUIPC = 4'd9,
        OP_LUI   = 4'd10
    } op_e;

    // Where the next PC comes from
    typedef enum logic [1:0] {
        TGT_SEQ  = 2'd0,
        TGT_REL  = 2'd1,
        TGT_JALR = 2'd2
    } tgt_e;

    // What goes to the destination register
    typedef enum logic [1:0] {
        WB_NONE  = 2'd0,
        WB_LINK  = 2'd1,
        WB_UPPER = 2'd2,
        WB_AUIPC = 2'd3
    } wb_e;

    // Comparator results shared by all six conditions
    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } cmp_flags_t;

endpackage

// File: rtl/nextpc_cmp.sv
`timescale 1ns/1ps
module nextpc_cmp
    import nextpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output cmp_flags_t      flags
);

    logic [XLEN:0] diff;
    logic          sign_differ;

    // One subtractor serves both orderings: the borrow gives the unsigned result,
    // and the signed result follows from the sign bits.
    always_comb begin
        diff        = {1'b0, op_a} - {1'b0, op_b};
        sign_differ = op_a[XLEN-1] ^ op_b[XLEN-1];
        flags.eq    = (op_a == op_b);
        flags.lt_u  = diff[XLEN];
        flags.lt_s  = sign_differ ? op_a[XLEN-1] : diff[XLEN];
    end

endmodule

// File: rtl/nextpc_adders.sv
`timescale 1ns/1ps
module nextpc_adders #(
    parameter int XLEN        = 32,
    parameter int INSN_BYTES  = 4,
    parameter int UPPER_SHIFT = 12
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] rel_pc,
    output logic [XLEN-1:0] jalr_pc,
    output logic [XLEN-1:0] upper_val,
    output logic [XLEN-1:0] auipc_val
);

    localparam logic [XLEN-1:0] STEP_BYTES = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] base_sum;

    always_comb begin
        seq_pc    = pc + STEP_BYTES;
        rel_pc    = pc + imm;
        base_sum  = rs1 + imm;
        jalr_pc   = {base_sum[XLEN-1:1], 1'b0};
        upper_val = imm << UPPER_SHIFT;
        auipc_val = pc + upper_val;
    end

endmodule

// File: rtl/nextpc_pcreg.sv
`timescale 1ns/1ps
module nextpc_pcreg #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [XLEN-1:0] d,
    output logic [XLEN-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VEC;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/nextpc_unit.sv
`timescale 1ns/1ps
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] RESET_VEC   = '0,
    parameter int              INSN_BYTES  = 4,
    parameter int              UPPER_SHIFT = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic [3:0]      op_sel,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] imm_val,
    output logic [XLEN-1:0] pc_out,
    output logic [XLEN-1:0] next_pc,
    output logic            taken,
    output logic            wb_en,
    output logic [XLEN-1:0] wb_val
);

    localparam logic [XLEN-1:0] STEP_BYTES = XLEN'(INSN_BYTES);

    op_e             op;
    cmp_flags_t      flags;
    tgt_e            tgt_sel;
    wb_e             wb_sel;
    logic            take_c;
    logic            jump_abs;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_pc;
    logic [XLEN-1:0] jalr_pc;
    logic [XLEN-1:0] upper_val;
    logic [XLEN-1:0] auipc_val;

    nextpc_cmp #(.XLEN(XLEN)) u_cmp (
        .op_a  (rs1_val),
        .op_b  (rs2_val),
        .flags (flags)
    );

    nextpc_adders #(
        .XLEN        (XLEN),
        .INSN_BYTES  (INSN_BYTES),
        .UPPER_SHIFT (UPPER_SHIFT)
    ) u_add (
        .pc        (pc_out),
        .rs1       (rs1_val),
        .imm       (imm_val),
        .seq_pc    (seq_pc),
        .rel_pc    (rel_pc),
        .jalr_pc   (jalr_pc),
        .upper_val (upper_val),
        .auipc_val (auipc_val)
    );

    nextpc_pcreg #(
        .XLEN      (XLEN),
        .RESET_VEC (RESET_VEC)
    ) u_pc (
        .clk  (clk),
        .rst  (rst),
        .load (step),
        .d    (next_pc),
        .q    (pc_out)
    );

    // Class decode: the branch condition, the jump kind and the writeback source
    always_comb begin
        op       = op_e'(op_sel);
        take_c   = 1'b0;
        jump_abs = 1'b0;
        wb_sel   = WB_NONE;
        unique case (op)
            OP_SEQ:   take_c = 1'b0;
            OP_BEQ:   take_c = flags.eq;
            OP_BNE:   take_c = !flags.eq;
            OP_BLT:   take_c = flags.lt_s;
            OP_BGE:   take_c = !flags.lt_s;
            OP_BLTU:  take_c = flags.lt_u;
            OP_BGEU:  take_c = !flags.lt_u;
            OP_JAL: begin
                take_c = 1'b1;
                wb_sel = WB_LINK;
            end
            OP_JALR: begin
                take_c   = 1'b1;
                jump_abs = 1'b1;
                wb_sel   = WB_LINK;
            end
            OP_AUIPC: wb_sel = WB_AUIPC;
            OP_LUI:   wb_sel = WB_UPPER;
            default:  take_c = 1'b0;
        endcase
        if (jump_abs) begin
            tgt_sel = TGT_JALR;
        end else if (take_c) begin
            tgt_sel = TGT_REL;
        end else begin
            tgt_sel = TGT_SEQ;
        end
    end

    // Output selection
    always_comb begin
        taken = take_c;
        unique case (tgt_sel)
            TGT_REL:  next_pc = rel_pc;
            TGT_JALR: next_pc = jalr_pc;
            default:  next_pc = seq_pc;
        endcase
        wb_en = (wb_sel != WB_NONE);
        unique case (wb_sel)
            WB_LINK:  wb_val = seq_pc;
            WB_UPPER: wb_val = upper_val;
            WB_AUIPC: wb_val = auipc_val;
            default:  wb_val = '0;
        endcase
    end

    // Assertions
    a_r2_seq_quiet: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd0) |-> (!taken && !wb_en && next_pc == pc_out + STEP_BYTES));

    a_r6_untaken_falls_through: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= 4'd1 && op_sel <= 4'd6 && !taken) |-> (next_pc == pc_out + STEP_BYTES));

    a_r8_jalr_even_target: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd8) |-> (next_pc[0] == 1'b0 && taken && wb_val == pc_out + STEP_BYTES));

    a_r11_step_loads: assert property (@(posedge clk) disable iff (rst)
        step |=> (pc_out == $past(next_pc)));

    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc_out));

    a_r13_no_write_no_value: assert property (@(posedge clk) disable iff (rst)
        !wb_en |-> (wb_val == '0));

endmodule

// File: tb/nextpc_unit_bench.sv
`timescale 1ns/1ps
module nextpc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic [31:0] imm_val = '0;
    logic [31:0] pc_out;
    logic [31:0] next_pc;
    logic        taken;
    logic        wb_en;
    logic [31:0] wb_val;

    int checks = 0;
    int failures = 0;

    logic [31:0] mpc = '0;
    bit          pc_known = 1'b0;
    string       pc_tag = "R1";

    always #5 clk = ~clk;

    nextpc_unit u_nextpc_unit (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .op_sel  (op_sel),
        .rs1_val (rs1_val),
        .rs2_val (rs2_val),
        .imm_val (imm_val),
        .pc_out  (pc_out),
        .next_pc (next_pc),
        .taken   (taken),
        .wb_en   (wb_en),
        .wb_val  (wb_val)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0:             return "R2";
            4'd1, 4'd2:       return "R3";
            4'd3, 4'd4:       return "R4";
            4'd5, 4'd6:       return "R5";
            4'd7:             return "R7";
            4'd8:             return "R8";
            4'd9:             return "R10";
            4'd10:            return "R9";
            default:          return "R12";
        endcase
    endfunction

    // One cycle: check the PC from the last edge, drive, check the results, advance the model
    task automatic cyc(input logic r, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] im, input logic st);
        logic        e_take;
        logic [31:0] e_next;
        logic        e_wen;
        logic [31:0] e_wb;
        string       t;
        @(negedge clk);
        if (pc_known) check(pc_tag, "pc_out", pc_out, mpc);
        rst = r; op_sel = op; rs1_val = a; rs2_val = b; imm_val = im; step = st;
        #1;
        e_take = 1'b0; e_wen = 1'b0; e_wb = 32'd0; e_next = mpc + 32'd4;
        case (op)
            4'd1: e_take = (a == b);
            4'd2: e_take = (a != b);
            4'd3: e_take = ($signed(a) < $signed(b));
            4'd4: e_take = ($signed(a) >= $signed(b));
            4'd5: e_take = (a < b);
            4'd6: e_take = (a >= b);
            4'd7: begin e_take = 1'b1; e_wen = 1'b1; e_wb = mpc + 32'd4; end
            4'd8: begin e_take = 1'b1; e_wen = 1'b1; e_wb = mpc + 32'd4; end
            4'd9: begin e_wen = 1'b1; e_wb = mpc + (im * 32'd4096); end
            4'd10: begin e_wen = 1'b1; e_wb = im * 32'd4096; end
            default: e_take = 1'b0;
        endcase
        if (op == 4'd8) e_next = (a + im) & 32'hFFFF_FFFE;
        else if (e_take) e_next = mpc + im;
        t = tag_of(op);
        if (!r && pc_known) begin
            check((op >= 4'd1 && op <= 4'd6) ? "R6" : t, "next_pc", next_pc, e_next);
            check(t, "taken", {31'd0, taken}, {31'd0, e_take});
            check((op >= 4'd1 && op <= 4'd6) ? "R6" : t, "wb_en", {31'd0, wb_en}, {31'd0, e_wen});
            check(e_wen ? t : "R13", "wb_val", wb_val, e_wb);
        end
        if (r) begin
            mpc = 32'd0; pc_known = 1'b1; pc_tag = "R1";
        end else begin
            if (st) mpc = e_next;
            pc_tag = "R11";
        end
    endtask

    initial begin
        logic [31:0] ra;
        // R1: reset under a jump with step high still lands on the vector
        cyc(1'b1, 4'd7, 32'h0, 32'h0, 32'h40, 1'b1);
        cyc(1'b1, 4'd7, 32'h0, 32'h0, 32'h40, 1'b1);
        // R1 / R2: first run cycle from the vector
        cyc(1'b0, 4'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        // R8: odd target loses bit 0; link is old PC+4
        cyc(1'b0, 4'd8, 32'h0000_1000, 32'h0, 32'h1, 1'b1);
        // R8: base equal to destination case still links old PC
        cyc(1'b0, 4'd8, 32'h0000_2003, 32'h0, 32'hFFFF_FFFE, 1'b1);
        // R3 / R6: equal taken backward, not-equal not taken
        cyc(1'b0, 4'd1, 32'h55, 32'h55, 32'hFFFF_FFF8, 1'b1);
        cyc(1'b0, 4'd2, 32'h55, 32'h55, 32'h100, 1'b1);
        cyc(1'b0, 4'd2, 32'h55, 32'h56, 32'h10, 1'b1);
        // R4: signed -1 < 1
        cyc(1'b0, 4'd3, 32'hFFFF_FFFF, 32'h1, 32'h20, 1'b1);
        cyc(1'b0, 4'd4, 32'hFFFF_FFFF, 32'h1, 32'h20, 1'b1);
        cyc(1'b0, 4'd4, 32'h7, 32'h7, 32'h8, 1'b1);
        // R5: unsigned 0xFFFFFFFF > 1
        cyc(1'b0, 4'd5, 32'hFFFF_FFFF, 32'h1, 32'h20, 1'b1);
        cyc(1'b0, 4'd6, 32'hFFFF_FFFF, 32'h1, 32'h20, 1'b1);
        cyc(1'b0, 4'd5, 32'h8000_0000, 32'h8000_0000, 32'h20, 1'b1);
        // R7: jump and link
        cyc(1'b0, 4'd7, 32'h0, 32'h0, 32'h0000_0800, 1'b1);
        // R9 / R10: upper immediates
        cyc(1'b0, 4'd10, 32'h0, 32'h0, 32'h000F_FFFF, 1'b1);
        cyc(1'b0, 4'd9, 32'h0, 32'h0, 32'h0000_0003, 1'b1);
        // R11: hold with a taken jump presented
        cyc(1'b0, 4'd7, 32'h0, 32'h0, 32'h400, 1'b0);
        cyc(1'b0, 4'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        // R12: unused codes fall through
        cyc(1'b0, 4'd13, 32'h1, 32'h1, 32'h100, 1'b1);
        cyc(1'b0, 4'd15, 32'h0, 32'h0, 32'h100, 1'b1);
        // Mixed traffic
        for (int i = 0; i < 300; i++) begin
            ra = $urandom;
            cyc(1'b0, 4'($urandom_range(0, 15)), ra,
                ($urandom_range(0, 3) == 0) ? ra : $urandom,
                $urandom, ($urandom_range(0, 4) != 0));
        end
        // R1: reset in mid-run
        cyc(1'b1, 4'd0, 32'h0, 32'h0, 32'h0, 1'b1);
        cyc(1'b0, 4'd0, 32'h0, 32'h0, 32'h0, 1'b0);
        cyc(1'b0, 4'd0, 32'h0, 32'h0, 32'h0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule